// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Spare-Bit Generator

This block sits in the transmit path of a 2.048 Mbit/s E1 framer. It receives the serial frame stream one bit per clock and sends the same stream out one clock later. The first bit of timeslot zero in every frame, the international spare bit, is replaced by a value the block generates. The first clock of each frame-sync pulse marks where a frame starts. A sync-frame flag, sampled at that instant, tells whether the frame is a sync frame or a non-sync frame.

When CRC mode is disabled, the spare bit carries one of two user bits. The choice depends on the frame type. When CRC mode is enabled, the block counts frames in a 16-frame multiframe made of two 8-frame halves (submultiframes). It runs a CRC-4 over each half. The four check bits are placed in the sync frames of the next half. The non-sync frames carry a fixed multiframe alignment pattern and the two user bits.

Top module: `e1_spare_bit_gen`

## Requirements
- R1: Every bit that is not a spare-bit position appears on `dout` one clock after it is presented on `din`, unchanged.
- R2: A frame starts on the first clock in which `fsync` is high after a clock in which it was low. The bit in that clock is the spare bit, and `dout` carries the generated value in its place one clock later.
- R3: The first frame start after reset is frame 0 when `sync_frm` is high at that start. At each later start the number becomes (previous + 1) mod 16, with bit 0 then forced to the inverse of `sync_frm`. Sync frames are therefore always even, and a repeated sync frame keeps the same even number.
- R4: With `crc_en` low, the spare bit equals `user_s` when `sync_frm` is high at the frame start, and `user_n` otherwise.
- R5: With `crc_en` high, the spare bits of frames 1, 3, 5, 7, 9 and 11 are 0, 0, 1, 0, 1, 1.
- R6: With `crc_en` high, frame 13 carries `user_s` and frame 15 carries `user_n`.
- R7: With `crc_en` high, the even frames carry the check word of the previous submultiframe. Frames 0 and 8 carry C1 (the most significant bit), frames 2 and 10 carry C2, frames 4 and 12 carry C3, and frames 6 and 14 carry C4 (the least significant bit).
- R8: The check word is the remainder of M(x)·x^4 divided by x^4+x+1. M is the stream of bits sent on `dout`, first bit first, from a frame-0 or frame-8 start up to the clock before the next such start. In CRC mode, the spare bits of even frames count as 0. The remainder starts again from zero at each such start.
- R9: The first check word after reset is 0000. Bits that arrive before the first frame start are not included in any check word.
- R10: While reset is asserted, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one data bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync pulse, high during timeslot zero; its first high clock is the spare bit |
| sync_frm | input | 1 | High when the current frame is a sync frame, sampled at the frame start |
| din | input | 1 | Serial frame data |
| crc_en | input | 1 | High selects CRC multiframe mode |
| user_s | input | 1 | User bit for sync frames (non-CRC) or frame 13 (CRC) |
| user_n | input | 1 | User bit for non-sync frames (non-CRC) or frame 15 (CRC) |
| dout | output | 1 | Frame data with the spare bit replaced, one cycle late |

## Verification
On every cycle, the in-line assertions check several local properties:
- data bits pass through with one cycle of delay;
- the frame number holds between frame starts and steps by one when the frame type agrees;
- a sync frame always lands on an even number;
- the check word changes only at submultiframe boundaries;
- the user-bit selection in non-CRC mode;
- the zero alignment bit of frame 1.

Only the bench scenarios can show that the check word placed in the next submultiframe is the correct CRC-4 remainder of the bits sent. The same holds for the full alignment pattern across a multiframe, the first all-zero word, and numbering when two sync frames arrive back to back. The bench compares these against a long-division reference.

// File: rtl/e1sb_pkg.sv
package e1sb_pkg;
  localparam int CRC_W      = 4;
  localparam int MF_FRAMES  = 16;
  localparam int SMF_FRAMES = 8;
  localparam int FN_W       = $clog2(MF_FRAMES);
  localparam int SMF_W      = $clog2(SMF_FRAMES);
  localparam int MAS_LEN    = 6;

  // alignment pattern, MSB goes into frame 1
  localparam logic [MAS_LEN-1:0] MAS_PAT = 6'b001011;

  typedef logic [CRC_W-1:0] crc_t;
  typedef logic [FN_W-1:0]  fnum_t;

  // one serial step of the divider, first bit of the block first
  function automatic crc_t crc_step(crc_t r, logic b, crc_t poly);
    logic fb;
    fb = r[CRC_W-1] ^ b;
    return {r[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/e1sb_reset_sync.sv
module e1sb_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/e1sb_frame_track.sv
module e1sb_frame_track
  import e1sb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fsync,
  input  logic  sync_frm,
  output logic  fs_start,
  output fnum_t fn_cur,
  output logic  run,
  output logic  smf_bound
);
  logic  fsync_q;
  fnum_t fn_q, fn_d;
  logic  aligned_q;
  logic [FN_W-2:0] fn_hi;

  always_comb begin
    fs_start  = fsync & ~fsync_q;
    fn_hi     = fn_q[FN_W-1:1] + (FN_W-1)'(fn_q[0]);
    fn_d      = aligned_q ? {fn_hi, ~sync_frm} : {{(FN_W-1){1'b0}}, ~sync_frm};
    fn_cur    = fs_start ? fn_d : fn_q;
    run       = aligned_q | fs_start;
    smf_bound = fs_start & (fn_d[SMF_W-1:0] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsync_q   <= 1'b0;
      fn_q      <= '0;
      aligned_q <= 1'b0;
    end else begin
      fsync_q <= fsync;
      if (fs_start) begin
        fn_q      <= fn_d;
        aligned_q <= 1'b1;
      end
    end
  end

  // R3: a sync frame always takes an even number
  a_r3_sync_even: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_start && sync_frm) |=> !fn_q[0]);

  // R3: frame type agreeing with count parity advances by one
  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_start && aligned_q && (sync_frm == fn_q[0]))
      |=> (fn_q == ($past(fn_q) + {{(FN_W-1){1'b0}}, 1'b1})));

  // R2: numbering moves only at a frame start
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_start |=> $stable(fn_q));
endmodule

// File: rtl/e1sb_crc_engine.sv
module e1sb_crc_engine
  import e1sb_pkg::*;
#(
  parameter crc_t POLY = 4'b0011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bound,
  input  logic bit_in,
  output crc_t word
);
  crc_t acc_q, acc_d, word_q, word_d, seed;

  always_comb begin
    seed   = bound ? '0 : acc_q;
    acc_d  = run ? crc_step(seed, bit_in, POLY) : acc_q;
    word_d = bound ? acc_q : word_q;
    word   = word_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      word_q <= '0;
    end else begin
      if (run)   acc_q  <= acc_d;
      if (bound) word_q <= word_d;
    end
  end

  // R8: latched word changes only at a submultiframe boundary
  a_r8_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bound |=> $stable(word_q));

  // R8: remainder restarts from zero at a boundary
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (bound && !bit_in) |=> (acc_q == '0));
endmodule

// File: rtl/e1sb_spare_sel.sv
module e1sb_spare_sel
  import e1sb_pkg::*;
(
  input  logic  crc_en,
  input  fnum_t fn,
  input  logic  sync_frm,
  input  logic  user_s,
  input  logic  user_n,
  input  crc_t  word,
  output logic  spare,
  output logic  c_pos
);
  always_comb begin
    c_pos = crc_en & ~fn[0];
    if (!crc_en)
      spare = sync_frm ? user_s : user_n;
    else if (!fn[0])
      spare = word[2'd3 - fn[2:1]];
    else if (fn[3:1] == 3'd6)
      spare = user_s;
    else if (fn[3:1] == 3'd7)
      spare = user_n;
    else
      spare = MAS_PAT[3'd5 - fn[3:1]];
  end
endmodule

// File: rtl/e1_spare_bit_gen.sv
module e1_spare_bit_gen
  import e1sb_pkg::*;
#(
  parameter crc_t CRC_POLY = 4'b0011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  input  logic sync_frm,
  input  logic din,
  input  logic crc_en,
  input  logic user_s,
  input  logic user_n,
  output logic dout
);
  logic  rst_s;
  logic  fs_start, run, smf_bound;
  fnum_t fn_cur;
  crc_t  word;
  logic  spare, c_pos;
  logic  bit_out, crc_bit;
  logic  dout_q;

  e1sb_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_s)
  );

  e1sb_frame_track u_trk (
    .clk(clk), .rst_n(rst_s), .fsync(fsync), .sync_frm(sync_frm),
    .fs_start(fs_start), .fn_cur(fn_cur), .run(run), .smf_bound(smf_bound)
  );

  e1sb_crc_engine #(.POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_s), .run(run), .bound(smf_bound),
    .bit_in(crc_bit), .word(word)
  );

  e1sb_spare_sel u_sel (
    .crc_en(crc_en), .fn(fn_cur), .sync_frm(sync_frm),
    .user_s(user_s), .user_n(user_n), .word(word),
    .spare(spare), .c_pos(c_pos)
  );

  always_comb begin
    bit_out = fs_start ? spare : din;
    crc_bit = (fs_start & c_pos) ? 1'b0 : bit_out;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) dout_q <= 1'b0;
    else        dout_q <= bit_out;
  end

  assign dout = dout_q;

  // R1: data bits pass with one cycle of delay
  a_r1_pass: assert property (@(posedge clk) disable iff (!rst_s)
    !fs_start |=> (dout == $past(din)));

  // R4: user bit chosen by frame type when CRC mode is off
  a_r4_user: assert property (@(posedge clk) disable iff (!rst_s)
    (fs_start && !crc_en)
      |=> (dout == ($past(sync_frm) ? $past(user_s) : $past(user_n))));

  // R5: frame 1 carries the first alignment zero
  a_r5_mas_first: assert property (@(posedge clk) disable iff (!rst_s)
    (fs_start && crc_en && (fn_cur == 4'd1)) |=> !dout);

  // R10: output low while held in reset
  always @(posedge clk) begin
    if (!rst_n) a_r10_reset_low: assert (dout == 1'b0);
  end
endmodule

// File: tb/e1_spare_bit_gen_test.sv
module e1_spare_bit_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int FBITS      = 64;
  localparam int MAXB       = 2048;

  logic clk = 1'b0;
  logic rst_n, fsync, sync_frm, din, crc_en, user_s, user_n;
  logic dout;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // reference model state
  bit       chk_valid;
  logic     exp_bit;
  string    exp_tag;
  bit       m_prev_fs;
  bit       m_aligned;
  bit [3:0] m_fn;
  bit [3:0] m_word;
  bit       m_first_word;
  int       m_cnt;
  bit       store [MAXB];
  bit       work  [MAXB+4];

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_spare_bit_gen uut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .sync_frm(sync_frm),
    .din(din), .crc_en(crc_en), .user_s(user_s), .user_n(user_n),
    .dout(dout)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dout=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // long division of block * x^4 by x^4 + x + 1 (R8)
  function automatic bit [3:0] ref_crc(input int n);
    bit [4:0] g;
    g = 5'b10011;
    for (int i = 0; i < n; i++) work[i] = store[i];
    for (int i = n; i < n + 4; i++) work[i] = 1'b0;
    for (int i = 0; i < n; i++)
      if (work[i])
        for (int k = 0; k < 5; k++) work[i+k] = work[i+k] ^ g[4-k];
    return {work[n], work[n+1], work[n+2], work[n+3]};
  endfunction

  task automatic step(input logic d, input logic fs, input logic sf,
                      input logic us, input logic un);
    bit start, realigned, outb, cb;
    bit [3:0] nf;
    @(negedge clk);
    if (chk_valid) check(dout, exp_bit, exp_tag);
    din = d; fsync = fs; sync_frm = sf; user_s = us; user_n = un;
    start = fs && !m_prev_fs;
    m_prev_fs = fs;
    outb = d;
    cb = d;
    exp_tag = "R1";
    if (start) begin
      nf = m_aligned ? (m_fn + 4'd1) : 4'd0;
      realigned = m_aligned && (nf[0] == sf);
      nf[0] = ~sf;
      m_aligned = 1;
      m_fn = nf;
      if (nf[2:0] == 3'd0) begin
        m_first_word = (m_cnt == 0) && !m_first_word ? 1'b1 : 1'b0;
        m_word = ref_crc(m_cnt);
        m_cnt = 0;
      end else if (nf[2:0] != 3'd0 && m_fn[3:0] != 4'd0) begin
        m_first_word = m_first_word;
      end
      if (!crc_en) begin
        outb = sf ? us : un;
        exp_tag = "R2 R4";
      end else if (!nf[0]) begin
        outb = m_word[3 - nf[2:1]];
        exp_tag = m_first_word ? "R2 R9" : "R2 R7 R8";
      end else begin
        case (nf)
          4'd1, 4'd3, 4'd7: begin outb = 1'b0; exp_tag = "R2 R5"; end
          4'd5, 4'd9, 4'd11: begin outb = 1'b1; exp_tag = "R2 R5"; end
          4'd13: begin outb = us; exp_tag = "R2 R6"; end
          default: begin outb = un; exp_tag = "R2 R6"; end
        endcase
      end
      if (realigned) exp_tag = {exp_tag, " R3"};
      cb = (crc_en && !nf[0]) ? 1'b0 : outb;
    end
    if (m_aligned) begin
      store[m_cnt] = cb;
      m_cnt++;
    end
    exp_bit = outb;
    chk_valid = 1;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 0; fsync = 0; sync_frm = 0; din = 1; crc_en = mode;
    user_s = 0; user_n = 0;
    repeat (3) @(negedge clk);
    check(dout, 1'b0, "R10");
    rst_n = 1;
    din = 0;
    repeat (4) @(negedge clk);
    chk_valid = 0; m_prev_fs = 0; m_aligned = 0; m_fn = 0;
    m_word = 0; m_cnt = 0; m_first_word = 0;
  endtask

  task automatic send_frame(input logic sf, input logic us, input logic un);
    for (int i = 0; i < FBITS; i++)
      step(1'($urandom), (i < 8), sf, us, un);
  endtask

  // R1 R2 R4: non-CRC pass-through and user bit choice
  task automatic t_plain();
    do_reset(1'b0);
    for (int i = 0; i < 5; i++) step(1'($urandom), 0, 0, 0, 0);
    for (int f = 0; f < 8; f++) send_frame(~f[0], f[1], f[2]);
    send_frame(1'b0, 1'b1, 1'b0);
    step(0, 0, 0, 0, 0);
  endtask

  // R5 R6 R7 R8 R9: CRC multiframes with random payload
  task automatic t_crc();
    do_reset(1'b1);
    for (int i = 0; i < 7; i++) step(1'($urandom), 0, 0, 0, 0);
    for (int f = 0; f < 48; f++)
      send_frame(~f[0], 1'($urandom), 1'($urandom));
    step(0, 0, 0, 0, 0);
  endtask

  // R3: a repeated sync frame keeps its even number
  task automatic t_realign();
    do_reset(1'b1);
    step(0, 0, 0, 0, 0);
    for (int f = 0; f < 5; f++) send_frame(~f[0], 1, 0);
    send_frame(1'b1, 1, 0);
    for (int f = 5; f < 40; f++) send_frame(~f[0], f[2], f[1]);
    step(0, 0, 0, 0, 0);
  endtask

  initial begin
    rst_n = 0; fsync = 0; sync_frm = 0; din = 0; crc_en = 0;
    user_s = 0; user_n = 0; chk_valid = 0;
    t_plain();
    t_crc();
    t_realign();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule